// File: doc/BRIEF.md
# PIO Sector Transfer Controller

This block is a register-mapped disk sector engine for a host bus. The host fills four task-file bytes that together form a 29-bit sector number, then writes a command byte. A read command makes the sector available at once: the block signals ready and pulses its interrupt line. The host then pulls 128 words through the 32-bit data port. A write command arms the block to accept 128 words, and the block flags ready only when the last word has landed. A bus-master read command is accepted but only parks the block, because another block performs that transfer. The sector data lives in an on-chip synchronous word store. The word index is the byte address (sector × 512 + byte count) divided by four, wrapped to the store depth.

The transfer sequencer has five named states. `ST_IDLE` is the state after reset. `ST_RD_XFER` is entered on command 0x20. `ST_WR_XFER` is entered on command 0x30. `ST_DMA_WAIT` is entered on command 0xC8. `ST_DONE` is entered from either transfer state when the byte count reaches 512. Any legal command moves every state to the matching command state (transitions *cmd_rd*, *cmd_wr*, *cmd_dma*). The transfer states leave only through *sector_end* to `ST_DONE`. Illegal commands and rejected data accesses keep the state (*reject*).

Host bus: one access per cycle. A write (`host_we`) takes priority over a read (`host_re`). Every read returns `host_rdata` with `host_rvalid` exactly one cycle later. Offset 0 is the data word, offsets 3..6 are task-file bytes (low byte of `host_wdata`), offset 7 is the command on write and the status on read, and offsets 1 and 2 read as zero.

Top module: `sector_pio_ctrl`

## Requirements
- R1: After reset, status is 0x00, `irq`, `err` and `host_rvalid` are low, and every task-file byte reads as 0.
- R2: Offsets 3, 4, 5 and 6 store and read back a full byte (in bits 7:0). Offsets 1 and 2 always read 0.
- R3: A command latches the sector number {off6[4:0], off5, off4, off3}. Later task-file writes do not move the transfer in progress. The data word index is (sector·512 + byte count)/4 modulo the store depth (1024 words by default).
- R4: Command 0x20 sets status to 0x40 and pulses `irq` high for exactly one cycle, both in the cycle after the command write. The block then accepts data-port reads from byte 0.
- R5: Command 0x30 sets status to 0x00, raises no `irq`, and accepts data-port writes from byte 0.
- R6: Command 0xC8 sets status to 0x00, raises no `irq` and moves no data. Data-port accesses after it are rejected.
- R7: In read mode, each offset-0 read returns the next stored word one cycle later and advances the count by 4.
- R8: In write mode, each offset-0 write stores the word and advances the count by 4. Status stays 0x00 until the 128th write, becomes 0x40 after it, and no `irq` is raised.
- R9: Any other command code sets `err` and leaves state, count and status unchanged.
- R10: A data-port access in the wrong direction sets `err`. It changes neither the store nor the count and returns 0 on a read.
- R11: After 512 bytes the count saturates. Further data accesses set `err`, change nothing, and stay rejected until a new command.
- R12: `err` is sticky and clears on the next legal command.
- R13: `host_rvalid` is high exactly in the cycle after an accepted read. Offset 7 reads the current status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (ignored when `host_we` is high) |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 32 | Write data; bytes use bits 7:0 |
| host_rdata | output | 32 | Read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| irq | output | 1 | One-cycle interrupt pulse |
| status | output | 8 | Status byte (0x00 or 0x40) |
| err | output | 1 | Sticky protocol error flag |

## Verification
The bench targets the direction asymmetry. If the interrupt were raised on write completion, the interrupt counter would move during a write sector. If status were asserted too early, it would read 0x40 after the 127th word instead of the 128th. Byte-order mistakes in the sector number are exposed by writing the sectors at low-byte 3 and mid-byte 3 and reading them back separately. A design that keeps counting past 512, or that lets rejected or wrong-direction accesses advance the count, returns shifted words on readback. A design that ignores the command latch shows the same fault when the task file is rewritten mid-transfer.

// File: rtl/sector_pio_pkg.sv
package sector_pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_XFER,
        ST_WR_XFER,
        ST_DMA_WAIT,
        ST_DONE
    } xfer_state_t;

    localparam logic [7:0] CMD_SECT_RD = 8'h20;
    localparam logic [7:0] CMD_SECT_WR = 8'h30;
    localparam logic [7:0] CMD_BM_RD   = 8'hC8;

    localparam logic [7:0] STAT_BUSY  = 8'h00;
    localparam logic [7:0] STAT_READY = 8'h40;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_TF0  = 3'd3;
    localparam logic [2:0] OFS_CMD  = 3'd7;

    localparam int TF_REGS  = 4;
    localparam int TOP_BITS = 5;
    localparam int LBA_W    = 8 * (TF_REGS - 1) + TOP_BITS;

endpackage

// File: rtl/sector_taskfile.sv
module sector_taskfile
    import sector_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_ofs,
    input  logic [7:0]       wr_byte,
    input  logic             latch,
    input  logic [2:0]       rd_ofs,
    output logic             rd_hit,
    output logic [7:0]       rd_byte,
    output logic [LBA_W-1:0] lba_q
);

    logic [TF_REGS-1:0][7:0] tf_q;
    logic [LBA_W-1:0]        lba_live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tf_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < TF_REGS; i++) begin
                if (wr_ofs == OFS_TF0 + 3'(i)) begin
                    tf_q[i] <= wr_byte;
                end
            end
        end
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_byte = 8'h00;
        for (int i = 0; i < TF_REGS; i++) begin
            if (rd_ofs == OFS_TF0 + 3'(i)) begin
                rd_hit  = 1'b1;
                rd_byte = tf_q[i];
            end
        end
    end

    assign lba_live = {tf_q[TF_REGS-1][TOP_BITS-1:0], tf_q[TF_REGS-2:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lba_q <= '0;
        end else if (latch) begin
            lba_q <= lba_live;
        end
    end

endmodule

// File: rtl/sector_xfer_fsm.sv
module sector_xfer_fsm
    import sector_pio_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int WORD_BYTES   = 4,
    parameter int CNT_W        = $clog2(SECTOR_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_code,
    input  logic             data_wr,
    input  logic             data_rd,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             lba_latch,
    output logic             acc_wr,
    output logic             acc_rd,
    output logic [7:0]       status,
    output logic             irq,
    output logic             err
);

    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(SECTOR_BYTES);
    localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(WORD_BYTES);

    xfer_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [7:0]       status_q, status_d;
    logic             irq_d, err_q, err_d;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        status_d  = status_q;
        irq_d     = 1'b0;
        err_d     = err_q;
        lba_latch = 1'b0;
        acc_wr    = 1'b0;
        acc_rd    = 1'b0;
        if (cmd_wr) begin
            unique case (cmd_code)
                CMD_SECT_RD: begin
                    state_d   = ST_RD_XFER;
                    cnt_d     = '0;
                    lba_latch = 1'b1;
                    status_d  = STAT_READY;
                    irq_d     = 1'b1;
                    err_d     = 1'b0;
                end
                CMD_SECT_WR: begin
                    state_d   = ST_WR_XFER;
                    cnt_d     = '0;
                    lba_latch = 1'b1;
                    status_d  = STAT_BUSY;
                    err_d     = 1'b0;
                end
                CMD_BM_RD: begin
                    state_d  = ST_DMA_WAIT;
                    cnt_d    = '0;
                    status_d = STAT_BUSY;
                    err_d    = 1'b0;
                end
                default: err_d = 1'b1;
            endcase
        end else if (data_wr || data_rd) begin
            unique case (state_q)
                ST_RD_XFER: begin
                    if (data_rd) begin
                        acc_rd = 1'b1;
                        cnt_d  = cnt_q + CNT_STEP;
                        if (cnt_d == CNT_END) begin
                            state_d  = ST_DONE;
                            status_d = STAT_READY;
                        end
                    end else begin
                        err_d = 1'b1;
                    end
                end
                ST_WR_XFER: begin
                    if (data_wr) begin
                        acc_wr = 1'b1;
                        cnt_d  = cnt_q + CNT_STEP;
                        if (cnt_d == CNT_END) begin
                            state_d  = ST_DONE;
                            status_d = STAT_READY;
                        end
                    end else begin
                        err_d = 1'b1;
                    end
                end
                ST_IDLE, ST_DMA_WAIT, ST_DONE: err_d = 1'b1;
                default: err_d = 1'b1;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STAT_BUSY;
            irq      <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq      <= irq_d;
            err_q    <= err_d;
        end
    end

    assign byte_cnt = cnt_q;
    assign status   = status_q;
    assign err      = err_q;

endmodule

// File: rtl/sector_word_store.sv
module sector_word_store #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/sector_pio_ctrl.sv
module sector_pio_ctrl
    import sector_pio_pkg::*;
#(
    parameter int MEM_WORDS    = 1024,
    parameter int SECTOR_BYTES = 512,
    parameter int DATA_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              irq,
    output logic [7:0]        status,
    output logic              err
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORD_SHIFT = $clog2(WORD_BYTES);
    localparam int SEC_SHIFT  = $clog2(SECTOR_BYTES);
    localparam int CNT_W      = SEC_SHIFT + 1;
    localparam int MEM_AW     = $clog2(MEM_WORDS);
    localparam int BADDR_W    = LBA_W + SEC_SHIFT;

    logic                wr_acc, rd_acc;
    logic                cmd_wr, data_wr, data_rd;
    logic [CNT_W-1:0]    byte_cnt;
    logic                lba_latch, acc_wr, acc_rd;
    logic [LBA_W-1:0]    lba_q;
    logic                tf_hit;
    logic [7:0]          tf_byte;
    logic [BADDR_W-1:0]  byte_addr;
    logic [MEM_AW-1:0]   word_idx;
    logic [DATA_W-1:0]   mem_q;
    logic [DATA_W-1:0]   rreg_q;
    logic                rsel_data_q, rvalid_q;

    assign wr_acc  = host_we;
    assign rd_acc  = host_re && !host_we;
    assign cmd_wr  = wr_acc && (host_addr == OFS_CMD);
    assign data_wr = wr_acc && (host_addr == OFS_DATA);
    assign data_rd = rd_acc && (host_addr == OFS_DATA);

    sector_taskfile u_taskfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_acc),
        .wr_ofs  (host_addr),
        .wr_byte (host_wdata[7:0]),
        .latch   (lba_latch),
        .rd_ofs  (host_addr),
        .rd_hit  (tf_hit),
        .rd_byte (tf_byte),
        .lba_q   (lba_q)
    );

    sector_xfer_fsm #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .WORD_BYTES   (WORD_BYTES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_code  (host_wdata[7:0]),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .byte_cnt  (byte_cnt),
        .lba_latch (lba_latch),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .status    (status),
        .irq       (irq),
        .err       (err)
    );

    assign byte_addr = {lba_q, {SEC_SHIFT{1'b0}}} + BADDR_W'(byte_cnt);
    assign word_idx  = MEM_AW'(byte_addr >> WORD_SHIFT);

    sector_word_store #(
        .DEPTH (MEM_WORDS),
        .WIDTH (DATA_W),
        .AW    (MEM_AW)
    ) u_store (
        .clk   (clk),
        .we    (acc_wr),
        .re    (acc_rd),
        .addr  (word_idx),
        .wdata (host_wdata),
        .rdata (mem_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q    <= 1'b0;
            rsel_data_q <= 1'b0;
            rreg_q      <= '0;
        end else begin
            rvalid_q    <= rd_acc;
            rsel_data_q <= acc_rd;
            if (rd_acc) begin
                if (host_addr == OFS_CMD) begin
                    rreg_q <= DATA_W'(status);
                end else if (tf_hit) begin
                    rreg_q <= DATA_W'(tf_byte);
                end else begin
                    rreg_q <= '0;
                end
            end
        end
    end

    assign host_rdata  = rsel_data_q ? mem_q : rreg_q;
    assign host_rvalid = rvalid_q;

endmodule

// File: rtl/sector_pio_ctrl_chk.sv
module sector_pio_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic        host_re,
    input logic [2:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic        host_rvalid,
    input logic        irq,
    input logic [7:0]  status,
    input logic        err
);

    logic cmd_w, rd_acc, legal;
    assign cmd_w  = host_we && (host_addr == 3'd7);
    assign rd_acc = host_re && !host_we;
    assign legal  = (host_wdata[7:0] == 8'h20) || (host_wdata[7:0] == 8'h30)
                 || (host_wdata[7:0] == 8'hC8);

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cmd_w && host_wdata[7:0] == 8'h20));

    assert_rd_cmd_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && host_wdata[7:0] == 8'h20) |=> (status == 8'h40 && irq));

    assert_wr_cmd_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && host_wdata[7:0] == 8'h30) |=> (status == 8'h00 && !irq));

    assert_bm_cmd_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && host_wdata[7:0] == 8'hC8) |=> (status == 8'h00 && !irq));

    assert_bad_cmd_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && !legal) |=> (err && $stable(status)));

    assert_err_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && legal) |=> !err);

    assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h00) || (status == 8'h40));

    assert_rvalid_set_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> host_rvalid);

    assert_rvalid_clr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !host_rvalid);

endmodule

bind sector_pio_ctrl sector_pio_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .host_re     (host_re),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .irq         (irq),
    .status      (status),
    .err         (err)
);

// File: tb/sector_pio_ctrl_tb.sv
module sector_pio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        irq;
    logic [7:0]  status;
    logic        err;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    always #2 clk = ~clk;

    sector_pio_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we),
        .host_re     (host_re),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .irq         (irq),
        .status      (status),
        .err         (err)
    );

    always @(negedge clk) if (rst_n && irq === 1'b1) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_re = 1'b1; host_addr = a;
        @(negedge clk);
        host_re = 1'b0;
        d = host_rdata;
        chk("R13 rvalid after read", {31'd0, host_rvalid}, 32'd1);
    endtask

    function automatic logic [31:0] pat(input int seed, input int i);
        return {seed[7:0], 8'hA5, i[15:0]} ^ 32'h5A00_3C00;
    endfunction

    task automatic set_lba(input logic [7:0] b3, b4, b5, b6);
        bus_write(3'd3, {24'd0, b3});
        bus_write(3'd4, {24'd0, b4});
        bus_write(3'd5, {24'd0, b5});
        bus_write(3'd6, {24'd0, b6});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 status", {24'd0, status}, 32'h00);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 rvalid", {31'd0, host_rvalid}, 32'd0);
        bus_read(3'd5, d);
        chk("R1 taskfile zero", d, 32'd0);
        bus_read(3'd7, d);
        chk("R13 status via offset 7", d, 32'h00);
        @(negedge clk);
        chk("R13 rvalid drops", {31'd0, host_rvalid}, 32'd0);
    endtask

    task automatic t_taskfile();
        logic [31:0] d;
        set_lba(8'h11, 8'h22, 8'h33, 8'hF4);
        bus_read(3'd3, d); chk("R2 off3", d, 32'h11);
        bus_read(3'd4, d); chk("R2 off4", d, 32'h22);
        bus_read(3'd5, d); chk("R2 off5", d, 32'h33);
        bus_read(3'd6, d); chk("R2 off6 full byte", d, 32'hF4);
        bus_write(3'd2, 32'h77);
        bus_read(3'd2, d); chk("R2 off2 zero", d, 32'h0);
        bus_read(3'd1, d); chk("R2 off1 zero", d, 32'h0);
    endtask

    task automatic t_write_sector(input logic [7:0] b3, b4, b5, b6, input int seed);
        int irq0;
        set_lba(b3, b4, b5, b6);
        bus_write(3'd7, 32'h30);
        irq0 = irq_cnt;
        chk("R5 status busy", {24'd0, status}, 32'h00);
        chk("R5 no irq", {31'd0, irq}, 32'd0);
        chk("R12 err cleared", {31'd0, err}, 32'd0);
        for (int i = 0; i < 128; i++) begin
            bus_write(3'd0, pat(seed, i));
            if (i == 126) chk("R8 busy before last word", {24'd0, status}, 32'h00);
        end
        chk("R8 ready after 128 words", {24'd0, status}, 32'h40);
        chk("R8 no irq on write", irq_cnt - irq0, 32'd0);
        bus_write(3'd0, 32'hDEAD_BEEF);
        chk("R11 extra write err", {31'd0, err}, 32'd1);
        chk("R11 status held", {24'd0, status}, 32'h40);
    endtask

    task automatic t_read_sector(input logic [7:0] b3, b4, b5, b6, input int seed);
        logic [31:0] d;
        int bad = 0;
        set_lba(b3, b4, b5, b6);
        bus_write(3'd7, 32'h20);
        chk("R4 irq pulse", {31'd0, irq}, 32'd1);
        chk("R4 status ready", {24'd0, status}, 32'h40);
        chk("R12 err cleared", {31'd0, err}, 32'd0);
        @(negedge clk);
        chk("R4 irq one cycle", {31'd0, irq}, 32'd0);
        set_lba(8'hFF, 8'hEE, 8'hDD, 8'hCC);
        for (int i = 0; i < 128; i++) begin
            bus_read(3'd0, d);
            if (d !== pat(seed, i)) begin
                if (bad == 0) chk("R7 R3 sector word", d, pat(seed, i));
                bad++;
            end
        end
        chk("R7 R3 whole sector mismatches", bad, 32'd0);
        bus_read(3'd0, d);
        chk("R11 extra read returns 0", d, 32'd0);
        chk("R11 extra read err", {31'd0, err}, 32'd1);
    endtask

    task automatic t_illegal();
        logic [31:0] d;
        set_lba(8'd3, 8'd0, 8'd0, 8'd0);
        bus_write(3'd7, 32'h20);
        bus_read(3'd0, d); chk("R7 word0", d, pat(1, 0));
        bus_read(3'd0, d); chk("R7 word1", d, pat(1, 1));
        bus_write(3'd7, 32'h55);
        chk("R9 err set", {31'd0, err}, 32'd1);
        chk("R9 status kept", {24'd0, status}, 32'h40);
        chk("R9 no irq", {31'd0, irq}, 32'd0);
        bus_read(3'd0, d); chk("R9 count unchanged", d, pat(1, 2));
        bus_write(3'd0, 32'h0BAD_0BAD);
        chk("R10 wrong-direction write err", {31'd0, err}, 32'd1);
        bus_read(3'd0, d); chk("R10 count unchanged", d, pat(1, 3));
    endtask

    task automatic t_wrong_read_in_write();
        logic [31:0] d;
        set_lba(8'd4, 8'd0, 8'd0, 8'd0);
        bus_write(3'd7, 32'h30);
        chk("R12 err cleared by write cmd", {31'd0, err}, 32'd0);
        bus_read(3'd0, d);
        chk("R10 wrong-direction read returns 0", d, 32'd0);
        chk("R10 wrong-direction read err", {31'd0, err}, 32'd1);
        for (int i = 0; i < 128; i++) bus_write(3'd0, pat(4, i));
        chk("R10 R8 ready after 128 words", {24'd0, status}, 32'h40);
        t_read_sector(8'd4, 8'd0, 8'd0, 8'd0, 4);
    endtask

    task automatic t_dma();
        logic [31:0] d;
        int irq0;
        set_lba(8'd3, 8'd0, 8'd0, 8'd0);
        irq0 = irq_cnt;
        bus_write(3'd7, 32'hC8);
        chk("R6 status busy", {24'd0, status}, 32'h00);
        chk("R12 err cleared", {31'd0, err}, 32'd0);
        bus_read(3'd0, d);
        chk("R6 data read rejected", d, 32'd0);
        chk("R6 err on read", {31'd0, err}, 32'd1);
        bus_write(3'd0, 32'h1234_5678);
        chk("R6 no irq", irq_cnt - irq0, 32'd0);
        bus_read(3'd7, d);
        chk("R13 status busy via offset 7", d, 32'h00);
        t_read_sector(8'd3, 8'd0, 8'd0, 8'd0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_taskfile();
        // R3: byte order of sector number (lba 3 vs lba 0x300, index 0)
        t_write_sector(8'd3, 8'd0, 8'd0, 8'hE0, 1);
        t_write_sector(8'd0, 8'd3, 8'd0, 8'd0, 2);
        t_read_sector(8'd3, 8'd0, 8'd0, 8'd0, 1);
        t_read_sector(8'd8, 8'd0, 8'd0, 8'hE0, 2);
        t_illegal();
        t_wrong_read_in_write();
        t_dma();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: all requirements, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule